// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

A passive observer attached to one load/store request port between an execution unit and the memory-side buffer that serves it. The port uses a handshake that is not fire-and-forget. The requester raises a load or store strobe and presents an address with a valid flag, and it must keep that address steady until the server drops busy. The server answers the address with a one-cycle accept pulse or a one-cycle exception pulse. A load ends with a one-cycle load-data strobe. A store ends one cycle after the requester's one-cycle store-data strobe. Busy falls on a different cycle for each of the three endings.

The monitor drives nothing on the port and does not look at data values. It follows each transaction with a five-state tracker (idle, awaiting accept, awaiting load data, awaiting store data, store drain), so it knows which rule applies in each cycle. It records every rule violation in its own sticky error bit and raises a combined error flag. It also keeps saturating counts of completed loads and completed stores. A synchronous clear returns the tracker to idle and zeroes the error bits and the counts.

Top module: `lsport_monitor`

## Requirements
- R1: Load request and store request high in the same cycle sets error bit 0.
- R2: Busy low in a cycle where a transaction must still be in progress sets error bit 1. This covers the first cycle after a request is raised, the wait for accept (unless an exception is signalled), the wait for load data (unless load data is signalled) and the wait for store data (unless store data is signalled).
- R3: A rising edge of the combined request while a transaction is open, or while busy is high, sets error bit 2.
- R4: Once the address-valid flag has been seen during a transaction, any cycle with busy high where that flag is low or the address differs from the captured value sets error bit 3.
- R5: An accept, exception or load-data pulse that lasts more than one cycle, or that arrives outside the state that expects it, sets error bit 4.
- R6: Accept and exception high together sets error bit 5.
- R7: Exception high while busy is high sets error bit 6.
- R8: Load-data strobe high while busy is high sets error bit 7.
- R9: Store-data strobe high in any state other than awaiting store data (for example before the accept, or for a second cycle) sets error bit 8.
- R10: Store-data strobe with busy low, or busy high in the cycle after the store-data strobe, sets error bit 9.
- R11: Error bits are sticky until clear, and `err_any` is high exactly when at least one error bit is set.
- R12: A load is counted in the cycle of its load-data strobe, and a store in its drain cycle. Exceptions are not counted. Each count stops at its all-ones value.
- R13: `clr` high zeroes all error bits, `err_any` and both counts at the next edge, and returns the tracker to idle.
- R14: After reset all error bits, `err_any` and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of errors, counts and tracker |
| ld_req | input | 1 | Load request strobe from requester |
| st_req | input | 1 | Store request strobe from requester |
| addr_vld | input | 1 | Address valid flag |
| addr | input | AW | Request address |
| addr_ack | input | 1 | Address accepted pulse from server |
| addr_err | input | 1 | Address exception pulse from server |
| busy | input | 1 | Transaction in progress flag from server |
| ld_vld | input | 1 | Load data valid strobe from server |
| st_vld | input | 1 | Store data valid strobe from requester |
| err_bits | output | 10 | Sticky per-rule error bits (bit n as listed in requirements) |
| err_any | output | 1 | OR of all error bits |
| ld_count | output | CNT_W | Saturating count of completed loads |
| st_count | output | CNT_W | Saturating count of completed stores |

## Verification
Legal loads, stores and exceptions are swept over every combination of zero to two accept wait cycles and zero to three data wait cycles. They must leave every error bit clear, and the counts must match totals computed in the bench. Each rule is then broken on its own by a targeted sequence, and exactly one error bit must be set. This separates rules that involve the same signals, such as busy dropped early versus busy high at the exception or at the load data. Counts are driven past saturation with a 4-bit counter width, and two violations in a row confirm that the error bits accumulate and are sticky.

// File: rtl/lsport_monitor.sv
module lsport_monitor #(
  parameter int AW    = 48,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld_req,
  input  logic             st_req,
  input  logic             addr_vld,
  input  logic [AW-1:0]    addr,
  input  logic             addr_ack,
  input  logic             addr_err,
  input  logic             busy,
  input  logic             ld_vld,
  input  logic             st_vld,
  output logic [9:0]       err_bits,
  output logic             err_any,
  output logic [CNT_W-1:0] ld_count,
  output logic [CNT_W-1:0] st_count
);
  localparam int NRULE = 10;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LDW, S_STW, S_DRAIN} trk_t;

  trk_t             st_q, st_d;
  logic             is_st_q, req_q, held_q, ack_q, exc_q, ldv_q;
  logic [AW-1:0]    addr_q;
  logic [NRULE-1:0] viol, err_q;
  logic [CNT_W-1:0] ld_cnt, st_cnt;

  wire req   = ld_req | st_req;
  wire idle  = (st_q == S_IDLE);
  wire start = req & ~req_q & idle;

  assign viol[0] = ld_req & st_req;
  assign viol[1] = ~busy & (((st_q == S_ADDR) & ~addr_err) |
                            ((st_q == S_LDW)  & ~ld_vld)   |
                            ((st_q == S_STW)  & ~st_vld));
  assign viol[2] = req & ~req_q & (~idle | busy);
  assign viol[3] = held_q & busy & (~addr_vld | (addr != addr_q));
  assign viol[4] = (addr_ack & (ack_q | (st_q != S_ADDR))) |
                   (addr_err & (exc_q | (st_q != S_ADDR))) |
                   (ld_vld   & (ldv_q | (st_q != S_LDW)));
  assign viol[5] = addr_ack & addr_err;
  assign viol[6] = addr_err & busy;
  assign viol[7] = ld_vld & busy;
  assign viol[8] = st_vld & (st_q != S_STW);
  assign viol[9] = ((st_q == S_STW) & st_vld & ~busy) | ((st_q == S_DRAIN) & busy);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start) st_d = S_ADDR;
      S_ADDR:  if (addr_err) st_d = S_IDLE;
               else if (addr_ack) st_d = is_st_q ? S_STW : S_LDW;
      S_LDW:   if (ld_vld) st_d = S_IDLE;
      S_STW:   if (st_vld) st_d = S_DRAIN;
      S_DRAIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  wire ld_done = (st_q == S_LDW) & ld_vld;
  wire st_done = (st_q == S_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      is_st_q <= 1'b0;
      req_q   <= 1'b0;
      held_q  <= 1'b0;
      ack_q   <= 1'b0;
      exc_q   <= 1'b0;
      ldv_q   <= 1'b0;
      addr_q  <= '0;
      err_q   <= '0;
      ld_cnt  <= '0;
      st_cnt  <= '0;
    end else begin
      req_q <= req;
      ack_q <= addr_ack;
      exc_q <= addr_err;
      ldv_q <= ld_vld;
      if (clr) begin
        st_q   <= S_IDLE;
        held_q <= 1'b0;
        err_q  <= '0;
        ld_cnt <= '0;
        st_cnt <= '0;
      end else begin
        st_q  <= st_d;
        err_q <= err_q | viol;
        if (start) is_st_q <= st_req & ~ld_req;
        if (st_d == S_IDLE) held_q <= 1'b0;
        else if (addr_vld & ~held_q & (start | ~idle)) begin
          held_q <= 1'b1;
          addr_q <= addr;
        end
        if (ld_done && ld_cnt != CNT_MAX) ld_cnt <= ld_cnt + CNT_ONE;
        if (st_done && st_cnt != CNT_MAX) st_cnt <= st_cnt + CNT_ONE;
      end
    end
  end

  assign err_bits = err_q;
  assign err_any  = |err_q;
  assign ld_count = ld_cnt;
  assign st_count = st_cnt;
endmodule

// File: rtl/lsport_monitor_sva.sv
module lsport_monitor_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             ld_req,
  input logic             st_req,
  input logic             addr_err,
  input logic             busy,
  input logic [9:0]       err_bits,
  input logic             err_any,
  input logic [CNT_W-1:0] ld_count,
  input logic [CNT_W-1:0] st_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  assert_dual_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && st_req && !clr) |=> err_bits[0]);

  assert_exc_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err && busy && !clr) |=> err_bits[6]);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

  assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_bits == '0 && !err_any && ld_count == '0 && st_count == '0));

  assert_ld_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (ld_count == $past(ld_count) || ld_count == $past(ld_count) + CONE));

  assert_ld_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_count == CMAX && !clr) |=> ld_count == CMAX);

  assert_st_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_count == CMAX && !clr) |=> st_count == CMAX);
endmodule

bind lsport_monitor lsport_monitor_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ld_req(ld_req), .st_req(st_req),
  .addr_err(addr_err), .busy(busy), .err_bits(err_bits), .err_any(err_any),
  .ld_count(ld_count), .st_count(st_count)
);

// File: tb/lsport_monitor_test.sv
module lsport_monitor_test;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic ld_req = 0, st_req = 0, addr_vld = 0, addr_ack = 0, addr_err = 0;
  logic busy = 0, ld_vld = 0, st_vld = 0;
  logic [AW-1:0] addr = '0;
  logic [9:0] err_bits;
  logic err_any;
  logic [CW-1:0] ld_count, st_count;
  int checks = 0, fails = 0, nld = 0, nst = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsport_monitor #(.AW(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld_req(ld_req), .st_req(st_req),
    .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack), .addr_err(addr_err),
    .busy(busy), .ld_vld(ld_vld), .st_vld(st_vld), .err_bits(err_bits),
    .err_any(err_any), .ld_count(ld_count), .st_count(st_count));

  task automatic cyc(); @(negedge clk); endtask

  task automatic quiet();
    ld_req = 0; st_req = 0; addr_vld = 0; addr_ack = 0; addr_err = 0;
    busy = 0; ld_vld = 0; st_vld = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_err(string req, int mask);
    chk(req, int'(err_bits), mask);
    chk(req, int'(err_any), (mask != 0) ? 1 : 0);
  endtask

  task automatic do_clear();
    quiet(); clr = 1; cyc(); clr = 0;
  endtask

  task automatic begin_req(bit is_st, logic [AW-1:0] a);
    ld_req = !is_st; st_req = is_st; addr_vld = 1; addr = a; busy = 0; cyc();
  endtask

  task automatic clean_ld(int aw, int dw, logic [AW-1:0] a);
    begin_req(0, a);
    busy = 1; repeat (aw) cyc();
    addr_ack = 1; cyc(); addr_ack = 0;
    repeat (dw) cyc();
    busy = 0; ld_vld = 1; cyc();
    quiet(); cyc();
    nld++;
  endtask

  task automatic clean_st(int aw, int dw, logic [AW-1:0] a);
    begin_req(1, a);
    busy = 1; repeat (aw) cyc();
    addr_ack = 1; cyc(); addr_ack = 0;
    repeat (dw) cyc();
    st_vld = 1; cyc();
    st_vld = 0; busy = 0; cyc();
    quiet(); cyc();
    nst++;
  endtask

  task automatic clean_exc(int aw, logic [AW-1:0] a);
    begin_req(0, a);
    busy = 1; repeat (aw) cyc();
    busy = 0; addr_err = 1; cyc();
    quiet(); cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R14 reset state
    chk_err("R14 errors", 0);
    chk("R14 ld_count", int'(ld_count), 0);
    chk("R14 st_count", int'(st_count), 0);

    // R1 both requests together
    ld_req = 1; st_req = 1; cyc();
    chk_err("R1", 1 << 0); do_clear();

    // R2 busy not raised after request
    begin_req(0, 8'h11); cyc();
    chk_err("R2 late", 1 << 1); do_clear();
    // R2 busy dropped while waiting for load data
    begin_req(0, 8'h12); busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    busy = 0; cyc();
    chk_err("R2 drop", 1 << 1); do_clear();

    // R3 new request edge while open
    begin_req(0, 8'h13); ld_req = 0; busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    ld_req = 1; cyc();
    chk_err("R3 open", 1 << 2); do_clear();
    // R3 request edge while busy high in idle
    busy = 1; ld_req = 1; addr_vld = 1; cyc();
    chk_err("R3 busy", 1 << 2); do_clear();

    // R4 address changed / flag dropped while busy
    begin_req(0, 8'h14); busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    addr = 8'h15; cyc();
    chk_err("R4 value", 1 << 3); do_clear();
    begin_req(1, 8'h16); busy = 1; cyc();
    addr_vld = 0; cyc();
    chk_err("R4 flag", 1 << 3); do_clear();

    // R5 accept pulse two cycles; load data outside its state
    begin_req(0, 8'h17); busy = 1; addr_ack = 1; cyc(); cyc();
    chk_err("R5 width", 1 << 4); do_clear();
    ld_vld = 1; cyc();
    chk_err("R5 stray", 1 << 4); do_clear();

    // R6 accept and exception together
    begin_req(0, 8'h18); addr_ack = 1; addr_err = 1; cyc();
    chk_err("R6", 1 << 5); do_clear();

    // R7 exception with busy high
    begin_req(0, 8'h19); busy = 1; addr_err = 1; cyc();
    chk_err("R7", 1 << 6); do_clear();

    // R8 load data with busy high
    begin_req(0, 8'h1a); busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    ld_vld = 1; cyc();
    chk_err("R8", 1 << 7); do_clear();

    // R9 store data before accept
    begin_req(1, 8'h1b); busy = 1; st_vld = 1; cyc();
    chk_err("R9 early", 1 << 8); do_clear();
    // R9 store data two cycles
    begin_req(1, 8'h1c); busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    st_vld = 1; cyc(); busy = 0; cyc();
    chk_err("R9 width", 1 << 8); do_clear();

    // R10 store data with busy low; busy high in drain
    begin_req(1, 8'h1d); busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    busy = 0; st_vld = 1; cyc();
    chk_err("R10 low", 1 << 9); do_clear();
    begin_req(1, 8'h1e); busy = 1; addr_ack = 1; cyc(); addr_ack = 0;
    st_vld = 1; cyc(); st_vld = 0; cyc();
    chk_err("R10 drain", 1 << 9); do_clear();

    // R11 sticky accumulation
    begin_req(0, 8'h1f); busy = 1; addr_err = 1; cyc();
    quiet(); cyc();
    chk_err("R11 hold", 1 << 6);
    ld_req = 1; st_req = 1; cyc();
    chk_err("R11 accum", (1 << 6) | (1 << 0)); do_clear();
    chk_err("R13 bits", 0);

    // R12 sweep of legal traffic
    for (int aw = 0; aw < 3; aw++)
      for (int dw = 0; dw < 4; dw++) begin
        clean_ld(aw, dw, AW'(aw * 16 + dw));
        clean_st(aw, dw, AW'(aw * 16 + dw + 8));
        clean_exc(aw, AW'(dw));
        chk_err("R12 legal", 0);
        chk("R12 ld", int'(ld_count), (nld < CMAX) ? nld : CMAX);
        chk("R12 st", int'(st_count), (nst < CMAX) ? nst : CMAX);
      end
    // R12 saturation
    for (int i = 0; i < 6; i++) begin
      clean_ld(0, i % 2, AW'(i));
      clean_st(i % 2, 0, AW'(i + 3));
    end
    chk("R12 ld sat", int'(ld_count), (nld < CMAX) ? nld : CMAX);
    chk("R12 st sat", int'(st_count), (nst < CMAX) ? nst : CMAX);
    chk_err("R12 legal sat", 0);

    // R13 clear of counts and errors
    ld_req = 1; st_req = 1; cyc();
    chk_err("R13 pre", 1 << 0);
    do_clear();
    chk_err("R13 post", 0);
    chk("R13 ld", int'(ld_count), 0);
    chk("R13 st", int'(st_count), 0);
    clean_ld(1, 1, 8'h42);
    chk("R13 restart", int'(ld_count), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule